// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Threshold FIFO

This block turns an asynchronous serial line into bytes. A 16x oversampling tick paces it. Each character can carry five to eight data bits and an optional parity bit. The receiver takes the bits least significant first, checks parity in the selected mode and checks the stop bit. It stores each character in a sixteen-entry receive queue together with three per-character flags: parity error, framing error and break.

The host sees the oldest stored character and its flags at the outputs. A one-cycle read strobe removes that character. The block raises a data-available indication once the queue holds at least the selected threshold. It raises a timeout indication when stored characters sit untouched for a while. It also reports overrun and a summary bit that is set while any stored character is flagged.

Baud-rate division and register access are done outside the block. The block takes its format and threshold fields as plain inputs. These fields are assumed to change only while the line is idle.

Top module: `uart_rx_fifo`

## Requirements
- R1: The length field selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data arrives least significant bit first. The character is presented right-aligned, and unused upper bits read as zero.
- R2: Bit 0 of the parity field enables a parity bit after the data. With the enable set, bits [2:1] pick the check: 00 is odd, 01 is even, 10 expects a 1 and 11 expects a 0. A mismatch sets the parity flag of that character.
- R3: A stop bit sampled low sets the framing flag of that character. The receiver then waits for the line to return high before it looks for another start bit.
- R4: When every sample from the start bit through the stop bit reads low, exactly one character is stored. Its data is 0x00, its break flag is set and its parity and framing flags are clear. Nothing more is stored until the line has returned high.
- R5: The line is sampled on the eighth tick of each bit period. A start bit that reads high at that point is dropped and stores nothing.
- R6: The queue holds 16 characters and shows the oldest one at the outputs. The data-ready output is high while the queue is not empty. The read strobe removes the oldest character, and a read strobe on an empty queue has no effect.
- R7: A character that completes while 16 are stored is discarded and sets overrun. Overrun stays set until the next read strobe or queue clear.
- R8: Data-available is high while the stored count is at least the threshold. The threshold field selects 00 = 1, 01 = 4, 10 = 8 and 11 = 14.
- R9: Timeout rises when the queue is not empty and no character has completed or been read for 4 character times. A character time is 16 ticks times (start + data + parity + one stop). Any completion, read or clear drops it.
- R10: The error summary output is high exactly while at least one stored character carries a parity, framing or break flag.
- R11: A pulse on the clear input empties the queue and clears overrun and the error summary.
- R12: After reset the queue is empty and every status output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| len_sel | input | 2 | Data length field |
| par_sel | input | 3 | Parity mode field |
| trig_sel | input | 2 | Data-available threshold field |
| fifo_clr | input | 1 | Clear pulse for the receive queue |
| rd_en | input | 1 | Read strobe, removes the oldest character |
| rd_data | output | 8 | Oldest stored character (zero when empty) |
| data_ready | output | 1 | Queue not empty |
| err_parity | output | 1 | Parity flag of the oldest character |
| err_frame | output | 1 | Framing flag of the oldest character |
| err_break | output | 1 | Break flag of the oldest character |
| overrun | output | 1 | A character was lost to a full queue |
| fifo_err | output | 1 | Some stored character is flagged |
| rx_avail | output | 1 | Stored count at or above the threshold |
| rx_timeout | output | 1 | Stored characters left idle for 4 character times |

## Verification
A character is written into the queue on the clock edge that consumes the eighth tick of its stop bit. Its data, flags, count, data-available and overrun are visible from the next falling edge on. The stimulus keeps the stop bit for all 16 ticks, so checks made when a send finishes are already 8 ticks past that write. The timeout counter therefore starts its count at 8. The threshold is checked one tick before and exactly on the tick that should raise timeout. A read or clear pulse is applied for one cycle between falling edges, and its effect is sampled at the following falling edge.

// File: rtl/urx_pkg.sv
package urx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HOLD
    } rx_st_e;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_ent_t;

    function automatic int trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    // start + data + optional parity + one stop
    function automatic logic [3:0] char_bits(input logic [1:0] len, input logic pen);
        return 4'd7 + {2'b00, len} + {3'b000, pen};
    endfunction

    function automatic logic ent_err(input rx_ent_t e);
        return e.perr | e.ferr | e.brk;
    endfunction

endpackage

// File: rtl/urx_deser.sv
module urx_deser
    import urx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic [2:0] par_sel,
    output logic       push,
    output rx_ent_t    ent
);

    localparam logic [3:0] MID  = 4'd7;
    localparam logic [3:0] LAST = 4'd15;

    typedef struct packed {
        rx_st_e            st;
        logic [3:0]        ph;
        logic [3:0]        nbit;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic              allz;
    } dz_t;

    dz_t q, d;

    logic [3:0]        nbits_w;
    logic [DATA_W-1:0] aligned;
    logic              exp_par;
    logic              brk_w;

    assign nbits_w = 4'd5 + {2'b00, len_sel};
    assign aligned = q.sh >> (4'd8 - nbits_w);
    assign brk_w   = q.allz & ~rxd;

    always_comb begin
        case (par_sel[2:1])
            2'b00:   exp_par = ~^aligned;
            2'b01:   exp_par = ^aligned;
            2'b10:   exp_par = 1'b1;
            default: exp_par = 1'b0;
        endcase
    end

    always_comb begin
        d    = q;
        push = 1'b0;
        ent  = '0;
        if (tick) begin
            if (q.st != S_IDLE && q.st != S_HOLD) begin
                d.ph = q.ph + 4'd1;
            end
            case (q.st)
                S_IDLE: begin
                    if (!rxd) begin
                        d.st   = S_START;
                        d.ph   = 4'd1;
                        d.nbit = '0;
                        d.allz = 1'b1;
                    end
                end
                S_START: begin
                    if (q.ph == MID && rxd) begin
                        d.st = S_IDLE;
                    end else if (q.ph == LAST) begin
                        d.st = S_DATA;
                    end
                end
                S_DATA: begin
                    if (q.ph == MID) begin
                        d.sh   = {rxd, q.sh[DATA_W-1:1]};
                        d.nbit = q.nbit + 4'd1;
                        d.allz = q.allz & ~rxd;
                    end
                    if (q.ph == LAST && q.nbit == nbits_w) begin
                        d.st = par_sel[0] ? S_PAR : S_STOP;
                    end
                end
                S_PAR: begin
                    if (q.ph == MID) begin
                        d.pbit = rxd;
                        d.allz = q.allz & ~rxd;
                    end
                    if (q.ph == LAST) begin
                        d.st = S_STOP;
                    end
                end
                S_STOP: begin
                    if (q.ph == MID) begin
                        push      = 1'b1;
                        ent.data  = aligned;
                        ent.brk   = brk_w;
                        ent.ferr  = ~rxd & ~brk_w;
                        ent.perr  = par_sel[0] & (q.pbit != exp_par) & ~brk_w;
                        d.st      = rxd ? S_IDLE : S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (rxd) begin
                        d.st = S_IDLE;
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // R4
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && ent.brk) |-> (ent.data == '0 && !ent.perr && !ent.ferr));

    // R1
    len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (q.nbit == nbits_w));

    // R3
    hold_after_low_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (ent.ferr || ent.brk)) |=> (q.st == S_HOLD));

endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  rx_ent_t                    wr_ent,
    input  logic                       pop_req,
    output rx_ent_t                    rd_ent,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovr,
    output logic                       err_any
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic [CW-1:0] errs;
        logic          ovr;
    } fq_t;

    fq_t q, d;
    rx_ent_t mem [DEPTH];

    logic full, do_pop, do_push;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (q.cnt == CW'(DEPTH));
    assign do_pop  = pop_req && (q.cnt != '0);
    assign do_push = push && (!full || do_pop);
    assign rd_ent  = mem[q.rptr];

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (do_push) d.wptr = nxt(q.wptr);
            if (do_pop)  d.rptr = nxt(q.rptr);
            d.cnt  = q.cnt + CW'(do_push) - CW'(do_pop);
            d.errs = q.errs + CW'(do_push && ent_err(wr_ent))
                            - CW'(do_pop && ent_err(rd_ent));
            if (push && !do_push) begin
                d.ovr = 1'b1;
            end else if (pop_req) begin
                d.ovr = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[q.wptr] <= wr_ent;
        end
    end

    assign count   = q.cnt;
    assign ovr     = q.ovr;
    assign err_any = (q.errs != '0);

    // R6
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && q.cnt == '0 && !push && !clr) |=> (q.cnt == '0));

    // R11
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.cnt == '0 && !q.ovr && q.errs == '0));

    // R10
    err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.errs <= q.cnt);

    // R7
    ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> ($past(q.cnt) == CW'(DEPTH)));

endmodule

// File: rtl/urx_timeout.sv
module urx_timeout #(
    parameter int TO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       nonempty,
    input  logic       activity,
    input  logic [3:0] bits,
    output logic       timeout
);

    localparam int MAX_BITS = 12;
    localparam int CW       = $clog2(TO_CHARS * 16 * MAX_BITS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tq_t;

    tq_t q, d;
    logic [CW-1:0] limit;

    assign limit = CW'(TO_CHARS * 16) * CW'(bits);

    always_comb begin
        d = q;
        if (!nonempty || activity) begin
            d.cnt = '0;
        end else if (tick && q.cnt < limit) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign timeout = nonempty && (q.cnt >= limit);

    // R9
    to_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(tick) && !$past(activity)));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       tick16,
    input  logic [1:0] len_sel,
    input  logic [2:0] par_sel,
    input  logic [1:0] trig_sel,
    input  logic       fifo_clr,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       data_ready,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_break,
    output logic       overrun,
    output logic       fifo_err,
    output logic       rx_avail,
    output logic       rx_timeout
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          push;
    rx_ent_t       wr_ent, head;
    logic [CW-1:0] count;
    logic          nonempty;

    urx_deser u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rxd     (rxd),
        .len_sel (len_sel),
        .par_sel (par_sel),
        .push    (push),
        .ent     (wr_ent)
    );

    urx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fifo_clr),
        .push    (push),
        .wr_ent  (wr_ent),
        .pop_req (rd_en),
        .rd_ent  (head),
        .count   (count),
        .ovr     (overrun),
        .err_any (fifo_err)
    );

    assign nonempty = (count != '0);

    urx_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .nonempty (nonempty),
        .activity (push | rd_en | fifo_clr),
        .bits     (char_bits(len_sel, par_sel[0])),
        .timeout  (rx_timeout)
    );

    assign data_ready = nonempty;
    assign rd_data    = nonempty ? head.data : '0;
    assign err_parity = nonempty & head.perr;
    assign err_frame  = nonempty & head.ferr;
    assign err_break  = nonempty & head.brk;
    assign rx_avail   = int'(count) >= trig_level(trig_sel);

    // R8
    avail_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail |-> data_ready);

endmodule

// File: tb/test_uart_rx_fifo.sv
`timescale 1ns/1ps
module test_uart_rx_fifo;

    logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic       rxd = 1'b1, rd_en = 1'b0, fifo_clr = 1'b0;
    logic [1:0] len_sel = 2'd3, trig_sel = 2'd0;
    logic [2:0] par_sel = 3'b000;
    logic [7:0] rd_data;
    logic data_ready, err_parity, err_frame, err_break, overrun, fifo_err, rx_avail, rx_timeout;

    int n_chk = 0, n_fail = 0;

    uart_rx_fifo i_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16),
        .len_sel(len_sel), .par_sel(par_sel), .trig_sel(trig_sel),
        .fifo_clr(fifo_clr), .rd_en(rd_en), .rd_data(rd_data),
        .data_ready(data_ready), .err_parity(err_parity), .err_frame(err_frame),
        .err_break(err_break), .overrun(overrun), .fifo_err(fifo_err),
        .rx_avail(rx_avail), .rx_timeout(rx_timeout)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    // fields: [14:13] length, [12:10] parity, [9:2] data, [1] corrupt parity, [0] low stop
    localparam logic [14:0] VEC [8] = '{
        {2'd3, 3'b000, 8'hA5, 1'b0, 1'b0},
        {2'd0, 3'b001, 8'h13, 1'b0, 1'b0},
        {2'd1, 3'b011, 8'h2A, 1'b1, 1'b0},
        {2'd2, 3'b101, 8'h55, 1'b0, 1'b0},
        {2'd3, 3'b111, 8'hC3, 1'b1, 1'b0},
        {2'd3, 3'b000, 8'h7E, 1'b0, 1'b1},
        {2'd0, 3'b001, 8'hFF, 1'b0, 1'b0},
        {2'd3, 3'b011, 8'h00, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            while (!tick16) @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        wait_ticks(16);
    endtask

    task automatic send_char(input logic [7:0] d, input logic flip, input logic lowstop);
        int n;
        logic [7:0] m;
        logic pb;
        n = 5 + int'(len_sel);
        m = d & 8'((1 << n) - 1);
        case (par_sel[2:1])
            2'b00:   pb = ~^m;
            2'b01:   pb = ^m;
            2'b10:   pb = 1'b1;
            default: pb = 1'b0;
        endcase
        send_bit(1'b0);
        for (int i = 0; i < n; i++) send_bit(d[i]);
        if (par_sel[0]) send_bit(pb ^ flip);
        send_bit(!lowstop);
        rxd = 1'b1;
        if (lowstop) wait_ticks(2);
    endtask

    task automatic pop();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear();
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 data_ready", data_ready, 0);
        chk("R12 status", {overrun, fifo_err, rx_avail, rx_timeout, err_parity, err_frame, err_break}, 0);

        // R6 read on empty has no effect
        pop();
        chk("R6 empty read", data_ready, 0);
        send_char(8'h3C, 1'b0, 1'b0);
        chk("R6 one stored", {data_ready, rd_data}, {1'b1, 8'h3C});
        pop();
        chk("R6 drained", data_ready, 0);

        // table walk: R1 R2 R3 R10
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ed;
            len_sel = VEC[i][14:13];
            par_sel = VEC[i][12:10];
            wait_ticks(2);
            send_char(VEC[i][9:2], VEC[i][1], VEC[i][0]);
            ed = VEC[i][9:2] & 8'((1 << (5 + int'(VEC[i][14:13]))) - 1);
            chk("R1 data", rd_data, ed);
            chk("R2 parity flag", err_parity, VEC[i][1]);
            chk("R3 frame flag", err_frame, VEC[i][0]);
            chk("R10 summary", fifo_err, VEC[i][1] | VEC[i][0]);
            chk("R4 no break", err_break, 0);
            pop();
            chk("R6 popped", data_ready, 0);
        end

        // R5 start glitch
        len_sel = 2'd3; par_sel = 3'b000;
        rxd = 1'b0; wait_ticks(4); rxd = 1'b1; wait_ticks(20);
        chk("R5 glitch dropped", data_ready, 0);
        send_char(8'h96, 1'b0, 1'b0);
        chk("R5 next char", {data_ready, rd_data}, {1'b1, 8'h96});
        pop();

        // R4 break with odd parity enabled (11 bit times low, held for 20)
        par_sel = 3'b001;
        rxd = 1'b0; wait_ticks(16 * 20); rxd = 1'b1; wait_ticks(4);
        chk("R4 break entry", {err_break, err_parity, err_frame, rd_data}, {3'b100, 8'h00});
        chk("R4 summary", fifo_err, 1);
        pop();
        chk("R4 single entry", data_ready, 0);

        // R10 summary follows stored flags
        par_sel = 3'b011;
        send_char(8'h61, 1'b0, 1'b0);
        send_char(8'h62, 1'b1, 1'b0);
        chk("R10 head clean, summary set", {err_parity, fifo_err}, 2'b01);
        pop();
        chk("R10 head flagged", {err_parity, fifo_err, rd_data}, {2'b11, 8'h62});
        pop();
        chk("R10 summary cleared", {fifo_err, data_ready}, 2'b00);

        // R9 timeout: 8N1 gives 640 ticks; 8 ticks already elapsed at return
        par_sel = 3'b000;
        send_char(8'h01, 1'b0, 1'b0);
        send_char(8'h02, 1'b0, 1'b0);
        wait_ticks(631);
        chk("R9 not yet", rx_timeout, 0);
        wait_ticks(1);
        chk("R9 raised", rx_timeout, 1);
        pop();
        chk("R9 read drops", {rx_timeout, data_ready}, 2'b01);
        clear();

        // R8 threshold of 4
        trig_sel = 2'b01;
        for (int i = 0; i < 3; i++) send_char(8'(8'h11 * (i + 1)), 1'b0, 1'b0);
        chk("R8 below 4", rx_avail, 0);
        send_char(8'h44, 1'b0, 1'b0);
        chk("R8 at 4", rx_avail, 1);
        pop();
        chk("R8 back to 3", rx_avail, 0);
        trig_sel = 2'b00;
        #1;
        chk("R8 threshold 1", rx_avail, 1);
        trig_sel = 2'b10;
        #1;
        chk("R8 threshold 8", rx_avail, 0);
        clear();

        // R7 overrun, threshold 14
        trig_sel = 2'b11;
        for (int i = 0; i < 17; i++) begin
            send_char(8'(8'h40 + i), 1'b0, 1'b0);
            if (i == 12) chk("R8 13 below 14", rx_avail, 0);
            if (i == 13) chk("R8 at 14", rx_avail, 1);
            if (i == 15) chk("R7 full no overrun", overrun, 0);
        end
        chk("R7 overrun set", {overrun, rd_data}, {1'b1, 8'h40});
        for (int i = 0; i < 16; i++) begin
            chk("R7 order", rd_data, 8'(8'h40 + i));
            pop();
            if (i == 0) chk("R7 read clears", overrun, 0);
        end
        chk("R7 extra discarded", data_ready, 0);

        // R11 clear with overrun and a flagged entry
        send_char(8'h20, 1'b0, 1'b1);
        for (int i = 1; i < 17; i++) send_char(8'(8'h20 + i), 1'b0, 1'b0);
        chk("R11 before clear", {overrun, fifo_err, rx_avail}, 3'b111);
        clear();
        chk("R11 after clear", {data_ready, overrun, fifo_err, rx_avail}, 4'b0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule